// File: doc/BRIEF.md
# Two-Queue Conversion Scheduler

This block decides which conversion command runs next on a single shared converter, drawing commands from two queues held in one 64-entry command table. Queue 1 always wins. Each queue moves between idle, active and paused; queue 2 can also be pending (triggered while queue 1 is busy) or suspended (pre-empted by queue 1). The combined state of both queues is reported as a 4-bit code. The scheduler also keeps the index of the last finished command and raises completion, pause and trigger-overrun flags.

The command table sits outside the block. The scheduler presents a command index, and the table answers combinationally with that entry's pause bit and end-of-queue bit. Conversions are issued over a valid/ready request channel. `conv_req_valid` stays asserted with a stable `conv_req_idx` until `conv_req_ready` accepts it. The one exception is a queue 1 pre-emption: in that case the request is withdrawn in the same cycle that `conv_abort` pulses. At most one conversion is outstanding at a time. The converter answers an accepted request with a one-cycle `conv_done`. `conv_abort` tells it to drop the request it holds.

When queue 1 pre-empts queue 2, the `resume_aborted` control input decides what queue 2 does once queue 1 finishes. If it is 0, queue 2 restarts from its first command. If it is 1, queue 2 re-runs the command that was cut off.

Top module: `cq_sched`

## Requirements
- R1: After reset, `state_code` is 0000, all flags are 0, `conv_req_valid` is 0 and `last_idx` is 0.
- R2: `state_code[3:2]` reports queue 1 (00 idle, 01 paused, 10 active). `state_code[1:0]` reports queue 2 (00 idle, 01 paused, 10 active, or suspended when queue 1 is active, 11 trigger pending). The two queues are never active together, and codes 11xx never occur.
- R3: Queue 1 starts at index 0 and queue 2 starts at index `q2_base`. A queue finishes when a command with its end-of-queue bit completes, or when queue 1 completes the entry just below `q2_base`, or when queue 2 completes index 63. On finishing, the queue goes idle and sets its completion flag. `irq_q1` and `irq_q2` equal that flag ANDed with `cie_q1` or `cie_q2`.
- R4: When a non-final command with its pause bit completes, its queue goes paused and sets its pause flag. The queue's next trigger continues at the following index.
- R5: A queue 1 trigger while queue 2 is active suspends queue 2. If a queue 2 request is outstanding and `conv_done` is low, the trigger also pulses `conv_abort`. Queue 1 then presents its request in the very next cycle.
- R6: When queue 1 leaves the active state, a suspended queue 2 becomes active. It restarts at `q2_base` if `resume_aborted` is 0, and it re-runs the aborted index if `resume_aborted` is 1.
- R7: A queue 2 trigger arriving while queue 1 is active makes an idle or paused queue 2 pending. Queue 2 starts as soon as queue 1 leaves the active state.
- R8: A queue 2 trigger arriving while queue 2 is pending, suspended or active sets the queue 2 overrun flag and changes no scheduling.
- R9: A queue 1 trigger arriving while queue 1 is active sets the queue 1 overrun flag and changes no scheduling.
- R10: If a queue 1 trigger falls in the same cycle as `conv_done` for queue 2, the command counts as completed: no abort is issued, `last_idx` takes its index, and queue 2's resume point moves past it.
- R11: A request that has not been accepted holds `conv_req_valid` and `conv_req_idx` until `conv_req_ready` is high or `conv_abort` pulses.
- R12: `flags` bits are bit 0 queue 1 completion, bit 1 queue 2 completion, bit 2 queue 1 pause, bit 3 queue 2 pause, bit 4 queue 1 overrun, bit 5 queue 2 overrun. A 1 in `flag_clr` clears the matching bit, and a set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_q1 | input | 1 | Queue 1 trigger pulse |
| trig_q2 | input | 1 | Queue 2 trigger pulse |
| resume_aborted | input | 1 | 1: re-run the aborted queue 2 command; 0: restart queue 2 |
| q2_base | input | 6 | First table index of queue 2 |
| cie_q1 | input | 1 | Queue 1 completion interrupt enable |
| cie_q2 | input | 1 | Queue 2 completion interrupt enable |
| flag_clr | input | 6 | Per-flag clear pulses |
| cmd_pause | input | 1 | Pause bit of the table entry at `conv_req_idx` |
| cmd_eoq | input | 1 | End-of-queue bit of the table entry at `conv_req_idx` |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts the request |
| conv_req_idx | output | 6 | Table index of the request or of the conversion in flight |
| conv_done | input | 1 | Accepted conversion finished |
| conv_abort | output | 1 | Drop the outstanding conversion |
| state_code | output | 4 | Combined queue state code |
| last_idx | output | 6 | Index of the last completed command |
| flags | output | 6 | Status flags |
| irq_q1 | output | 1 | Queue 1 completion interrupt |
| irq_q2 | output | 1 | Queue 2 completion interrupt |

## Verification
Two functions can collide in one cycle: the pre-emption of queue 2 by a queue 1 trigger, and the completion of queue 2's conversion in flight. The bench counts converter acceptances and knows the fixed converter latency. From these it places the queue 1 trigger exactly on the cycle where `conv_done` rises for a queue 2 command. It also places the trigger one cycle after acceptance, which produces the plain abort case for comparison. In the colliding case it judges that no abort was counted, that `last_idx` holds the finished index, and that with `resume_aborted` set queue 2 later resumes at the following index rather than repeating the finished one.

// File: rtl/cq_pkg.sv
package cq_pkg;
  typedef enum logic [2:0] {
    QS_IDLE, QS_PAUSED, QS_ACTIVE, QS_PENDING, QS_SUSP
  } qstate_t;

  typedef enum logic [1:0] {
    PH_NONE, PH_REQ, PH_WAIT
  } phase_t;

  localparam int NFLAGS = 6;
  localparam int F_CF1  = 0;
  localparam int F_CF2  = 1;
  localparam int F_PF1  = 2;
  localparam int F_PF2  = 3;
  localparam int F_TOR1 = 4;
  localparam int F_TOR2 = 5;
endpackage

// File: rtl/cq_status_enc.sv
module cq_status_enc
  import cq_pkg::*;
(
  input  qstate_t    q1,
  input  qstate_t    q2,
  output logic [3:0] code
);
  always_comb begin
    case (q1)
      QS_ACTIVE: code[3:2] = 2'b10;
      QS_PAUSED: code[3:2] = 2'b01;
      default:   code[3:2] = 2'b00;
    endcase
    case (q2)
      QS_PAUSED:         code[1:0] = 2'b01;
      QS_ACTIVE, QS_SUSP: code[1:0] = 2'b10;
      QS_PENDING:        code[1:0] = 2'b11;
      default:           code[1:0] = 2'b00;
    endcase
  end
endmodule

// File: rtl/cq_end_check.sv
module cq_end_check #(
  parameter int IDX_W = 6
) (
  input  logic [IDX_W-1:0] idx,
  input  logic [IDX_W-1:0] q2_base,
  input  logic             is_q2,
  input  logic             eoq,
  output logic             last
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] nxt;
  assign nxt = idx + 1'b1;

  always_comb begin
    last = eoq || (idx == LAST_IDX) || (!is_q2 && (nxt == q2_base));
  end
endmodule

// File: rtl/cq_flag_bank.sv
module cq_flag_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      r <= 1'b0;
      else if (set[g]) r <= 1'b1;
      else if (clr[g]) r <= 1'b0;
    end
    assign flags[g] = r;

    // R12
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> flags[g]);
  end
endmodule

// File: rtl/cq_seq.sv
module cq_seq
  import cq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_q1,
  input  logic             trig_q2,
  input  logic             resume_aborted,
  input  logic [IDX_W-1:0] q2_base,
  input  logic             cmd_pause,
  input  logic             cmd_eoq,
  input  logic             conv_req_ready,
  input  logic             conv_done,
  output logic             conv_req_valid,
  output logic [IDX_W-1:0] conv_req_idx,
  output logic             conv_abort,
  output qstate_t          q1_st,
  output qstate_t          q2_st,
  output logic [IDX_W-1:0] last_idx,
  output logic [NFLAGS-1:0] flag_set
);
  qstate_t q1, q2, n_q1, n_q2;
  phase_t  ph, n_ph;
  logic    own, n_own;
  logic [IDX_W-1:0] p1, p2, idx, last, n_p1, n_p2, n_idx, n_last;
  logic done_ev, is_last, abort;

  cq_end_check #(.IDX_W(IDX_W)) u_end (
    .idx    (idx),
    .q2_base(q2_base),
    .is_q2  (own),
    .eoq    (cmd_eoq),
    .last   (is_last)
  );

  always_comb begin
    n_q1 = q1;  n_q2 = q2;  n_p1 = p1;  n_p2 = p2;
    n_ph = ph;  n_own = own; n_idx = idx; n_last = last;
    flag_set = '0;
    abort = 1'b0;
    done_ev = (ph == PH_WAIT) && conv_done;

    if (ph == PH_REQ && conv_req_ready) n_ph = PH_WAIT;

    // completion of the conversion in flight
    if (done_ev) begin
      n_ph   = PH_NONE;
      n_last = idx;
      if (!own) begin
        if (is_last) begin
          n_q1 = QS_IDLE;
          flag_set[F_CF1] = 1'b1;
        end else begin
          n_p1 = idx + 1'b1;
          if (cmd_pause) begin
            n_q1 = QS_PAUSED;
            flag_set[F_PF1] = 1'b1;
          end
        end
      end else begin
        if (is_last) begin
          n_q2 = QS_IDLE;
          flag_set[F_CF2] = 1'b1;
        end else begin
          n_p2 = idx + 1'b1;
          if (cmd_pause) begin
            n_q2 = QS_PAUSED;
            flag_set[F_PF2] = 1'b1;
          end
        end
      end
    end

    // queue 1 trigger, with pre-emption of queue 2
    if (trig_q1) begin
      if (q1 == QS_ACTIVE) begin
        flag_set[F_TOR1] = 1'b1;
      end else begin
        if (q1 == QS_IDLE) n_p1 = '0;
        n_q1 = QS_ACTIVE;
        if (n_q2 == QS_ACTIVE) begin
          n_q2 = QS_SUSP;
          if (own && ph != PH_NONE && !done_ev) begin
            abort = 1'b1;
            n_ph  = PH_NONE;
          end
        end
      end
    end

    // queue 2 trigger
    if (trig_q2) begin
      if (q2 == QS_IDLE || q2 == QS_PAUSED) begin
        if (q2 == QS_IDLE) n_p2 = q2_base;
        n_q2 = (n_q1 == QS_ACTIVE) ? QS_PENDING : QS_ACTIVE;
      end else begin
        flag_set[F_TOR2] = 1'b1;
      end
    end

    // hand-off when queue 1 stops being active
    if (q1 == QS_ACTIVE && n_q1 != QS_ACTIVE) begin
      if (n_q2 == QS_PENDING) begin
        n_q2 = QS_ACTIVE;
      end else if (n_q2 == QS_SUSP) begin
        n_q2 = QS_ACTIVE;
        if (!resume_aborted) n_p2 = q2_base;
      end
    end

    // issue the next command of the active queue
    if ((ph == PH_NONE || abort) && n_ph == PH_NONE) begin
      if (n_q1 == QS_ACTIVE) begin
        n_ph = PH_REQ; n_own = 1'b0; n_idx = n_p1;
      end else if (n_q2 == QS_ACTIVE) begin
        n_ph = PH_REQ; n_own = 1'b1; n_idx = n_p2;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q1 <= QS_IDLE;  q2 <= QS_IDLE;
      p1 <= '0;       p2 <= '0;
      ph <= PH_NONE;  own <= 1'b0;
      idx <= '0;      last <= '0;
    end else begin
      q1 <= n_q1;  q2 <= n_q2;
      p1 <= n_p1;  p2 <= n_p2;
      ph <= n_ph;  own <= n_own;
      idx <= n_idx; last <= n_last;
    end
  end

  assign conv_req_valid = (ph == PH_REQ);
  assign conv_req_idx   = idx;
  assign conv_abort     = abort;
  assign q1_st          = q1;
  assign q2_st          = q2;
  assign last_idx       = last;

  // R2
  not_both_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(q1 == QS_ACTIVE && q2 == QS_ACTIVE));

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_req_valid && !conv_req_ready && !conv_abort) |=>
      (conv_req_valid && $stable(conv_req_idx)));

  // R5
  preempt_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_abort |=> (q1 == QS_ACTIVE && q2 == QS_SUSP && conv_req_valid));

  // R7
  pend_needs_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q2 == QS_PENDING) |-> (q1 == QS_ACTIVE));
endmodule

// File: rtl/cq_sched.sv
module cq_sched
  import cq_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_q1,
  input  logic             trig_q2,
  input  logic             resume_aborted,
  input  logic [IDX_W-1:0] q2_base,
  input  logic             cie_q1,
  input  logic             cie_q2,
  input  logic [5:0]       flag_clr,
  input  logic             cmd_pause,
  input  logic             cmd_eoq,
  output logic             conv_req_valid,
  input  logic             conv_req_ready,
  output logic [IDX_W-1:0] conv_req_idx,
  input  logic             conv_done,
  output logic             conv_abort,
  output logic [3:0]       state_code,
  output logic [IDX_W-1:0] last_idx,
  output logic [5:0]       flags,
  output logic             irq_q1,
  output logic             irq_q2
);
  qstate_t q1_st, q2_st;
  logic [NFLAGS-1:0] flag_set;

  cq_seq #(.IDX_W(IDX_W)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .trig_q1       (trig_q1),
    .trig_q2       (trig_q2),
    .resume_aborted(resume_aborted),
    .q2_base       (q2_base),
    .cmd_pause     (cmd_pause),
    .cmd_eoq       (cmd_eoq),
    .conv_req_ready(conv_req_ready),
    .conv_done     (conv_done),
    .conv_req_valid(conv_req_valid),
    .conv_req_idx  (conv_req_idx),
    .conv_abort    (conv_abort),
    .q1_st         (q1_st),
    .q2_st         (q2_st),
    .last_idx      (last_idx),
    .flag_set      (flag_set)
  );

  cq_status_enc u_enc (
    .q1  (q1_st),
    .q2  (q2_st),
    .code(state_code)
  );

  cq_flag_bank #(.N(NFLAGS)) u_flags (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (flag_set),
    .clr  (flag_clr),
    .flags(flags)
  );

  assign irq_q1 = flags[F_CF1] & cie_q1;
  assign irq_q2 = flags[F_CF2] & cie_q2;

  // R2
  no_reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_code[3:2] != 2'b11);

  // R9
  tor1_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[F_TOR1]) |-> $past(trig_q1));
endmodule

// File: tb/cq_sched_tb.sv
`timescale 1ns/1ps
module cq_sched_tb;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_q1 = 0, trig_q2 = 0, resume_aborted = 0;
  logic [5:0] q2_base = 6'd8;
  logic cie_q1 = 1, cie_q2 = 0;
  logic [5:0] flag_clr = '0;
  logic cmd_pause, cmd_eoq;
  logic conv_req_valid, conv_req_ready = 0, conv_done = 0, conv_abort;
  logic [5:0] conv_req_idx, last_idx, flags;
  logic [3:0] state_code;
  logic irq_q1, irq_q2;

  logic [63:0] pause_tab = '0;
  logic [63:0] eoq_tab   = '0;
  assign cmd_pause = pause_tab[conv_req_idx];
  assign cmd_eoq   = eoq_tab[conv_req_idx];

  int vectors = 0, miscompares = 0;
  int acc_cnt = 0, abort_cnt = 0;
  int exp_q[$];
  logic busy = 0, stall = 0;
  int cnt = 0;

  always #2 clk = ~clk;

  cq_sched u_dut (
    .clk(clk), .rst_n(rst_n), .trig_q1(trig_q1), .trig_q2(trig_q2),
    .resume_aborted(resume_aborted), .q2_base(q2_base),
    .cie_q1(cie_q1), .cie_q2(cie_q2), .flag_clr(flag_clr),
    .cmd_pause(cmd_pause), .cmd_eoq(cmd_eoq),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready),
    .conv_req_idx(conv_req_idx), .conv_done(conv_done),
    .conv_abort(conv_abort), .state_code(state_code),
    .last_idx(last_idx), .flags(flags), .irq_q1(irq_q1), .irq_q2(irq_q2)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_seq(input int first, input int last);
    for (int i = first; i <= last; i++) exp_q.push_back(i);
  endtask

  // converter model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      conv_done = 1'b0;
      if (busy) begin
        cnt--;
        if (cnt == 0) begin conv_done = 1'b1; busy = 1'b0; end
      end
      conv_req_ready = !busy && !stall && rst_n;
      #0.5;
      if (conv_abort) begin
        busy = 1'b0;
        abort_cnt++;
      end else if (conv_req_valid && conv_req_ready) begin
        acc_cnt++;
        busy = 1'b1;
        cnt = LAT;
        if (exp_q.size() == 0) begin
          check("R3 unexpected request", int'(conv_req_idx), 99);
        end else begin
          check("R3/R6 request order", int'(conv_req_idx), exp_q.pop_front());
        end
      end
    end
  end

  task automatic pulse(input logic a, input logic b, input logic [5:0] clr);
    @(negedge clk);
    trig_q1 = a; trig_q2 = b; flag_clr = clr;
    @(negedge clk);
    trig_q1 = 0; trig_q2 = 0; flag_clr = '0;
  endtask

  task automatic wait_quiet(input string req);
    int n = 0;
    while ((state_code != 0 || busy || conv_req_valid) && n < 400) begin
      @(negedge clk); n++;
    end
    check({req, " finished"}, int'(n < 400), 1);
    check({req, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  task automatic wait_code(input logic [3:0] c);
    int n = 0;
    while (state_code != c && n < 400) begin @(negedge clk); n++; end
  endtask

  task automatic clear_all();
    pulse(0, 0, 6'h3f);
    check("R12 flags cleared", int'(flags), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int ab;
    eoq_tab[3] = 1'b1;
    eoq_tab[11] = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 state code", int'(state_code), 0);
    check("R1 flags", int'(flags), 0);
    check("R1 valid", int'(conv_req_valid), 0);
    check("R1 last idx", int'(last_idx), 0);
    rst_n = 1'b1;

    // R3 queue 1 alone
    push_seq(0, 3);
    pulse(1, 0, 0);
    check("R2 code q1 active", int'(state_code), 4'b1000);
    wait_quiet("R3 q1 run");
    check("R3 cf1 flag", int'(flags[0]), 1);
    check("R3 irq_q1 enabled", int'(irq_q1), 1);
    check("R3 last idx q1", int'(last_idx), 3);
    clear_all();

    // R3/R11 queue 2 alone with back-pressure
    stall = 1;
    push_seq(8, 11);
    pulse(0, 1, 0);
    check("R2 code q2 active", int'(state_code), 4'b0010);
    repeat (3) @(negedge clk);
    check("R11 valid held", int'(conv_req_valid), 1);
    check("R11 idx held", int'(conv_req_idx), 8);
    stall = 0;
    wait_quiet("R3 q2 run");
    check("R3 cf2 flag", int'(flags[1]), 1);
    check("R3 irq_q2 masked", int'(irq_q2), 0);
    clear_all();

    // R4 pause in queue 1
    pause_tab[1] = 1'b1;
    push_seq(0, 3);
    pulse(1, 0, 0);
    wait_code(4'b0100);
    check("R4 paused code", int'(state_code), 4'b0100);
    check("R4 pf1 flag", int'(flags[2]), 1);
    check("R4 last idx at pause", int'(last_idx), 1);
    pulse(1, 0, 0);
    wait_quiet("R4 resume after pause");
    pause_tab[1] = 1'b0;
    clear_all();

    // R7/R8 pending queue 2 and its overrun
    push_seq(0, 3);
    push_seq(8, 11);
    pulse(1, 0, 0);
    pulse(0, 1, 0);
    check("R7 pending code", int'(state_code), 4'b1011);
    pulse(0, 1, 0);
    check("R8 tor2 flag", int'(flags[5]), 1);
    check("R8 code unchanged", int'(state_code), 4'b1011);
    wait_quiet("R7 pending start");
    clear_all();

    // R9 queue 1 overrun, with simultaneous clear (set wins, R12)
    push_seq(0, 3);
    pulse(1, 0, 0);
    pulse(1, 0, 6'b010000);
    check("R9 tor1 flag", int'(flags[4]), 1);
    check("R12 set beats clear", int'(flags[4]), 1);
    check("R9 code unchanged", int'(state_code), 4'b1000);
    wait_quiet("R9 run undisturbed");
    clear_all();

    // R5/R6 pre-emption, restart at base
    resume_aborted = 0;
    push_seq(8, 9); push_seq(0, 3); push_seq(8, 11);
    ab = abort_cnt;
    pulse(0, 1, 0);
    wait (acc_cnt == 0 || exp_q.size() == 8);
    pulse(1, 0, 0);
    check("R5 abort seen", abort_cnt - ab, 1);
    check("R5 code suspended", int'(state_code), 4'b1010);
    check("R5 q1 request at once", int'(conv_req_valid), 1);
    check("R5 q1 request idx", int'(conv_req_idx), 0);
    wait_quiet("R6 restart");
    clear_all();

    // R6 pre-emption, re-run aborted command
    resume_aborted = 1;
    push_seq(8, 9); push_seq(0, 3); push_seq(9, 11);
    ab = abort_cnt;
    pulse(0, 1, 0);
    wait (exp_q.size() == 7);
    pulse(1, 0, 0);
    check("R6 abort seen", abort_cnt - ab, 1);
    wait_quiet("R6 re-run");
    clear_all();

    // R10 queue 1 trigger coincides with queue 2 done
    push_seq(8, 9); push_seq(0, 3); push_seq(10, 11);
    ab = abort_cnt;
    pulse(0, 1, 0);
    wait (exp_q.size() == 6);
    repeat (2) @(negedge clk);
    pulse(1, 0, 0);
    check("R10 no abort", abort_cnt - ab, 0);
    check("R10 last idx", int'(last_idx), 9);
    check("R10 code suspended", int'(state_code), 4'b1010);
    wait_quiet("R10 resume past done");
    clear_all();

    // R3 queue 1 ends below q2_base, queue 2 ends at table end
    eoq_tab = '0;
    q2_base = 6'd3;
    push_seq(0, 2);
    pulse(1, 0, 0);
    wait_quiet("R3 q1 stops at base");
    check("R3 last below base", int'(last_idx), 2);
    q2_base = 6'd60;
    push_seq(60, 63);
    pulse(0, 1, 0);
    wait_quiet("R3 q2 stops at 63");
    check("R3 last at table end", int'(last_idx), 63);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule